// File: doc/BRIEF.md
# Bidirectional Reset Pin Controller

This block owns the single reset pin of a small 8-bit microcontroller core. In the inbound direction it qualifies the pin level: the core reset is raised only after the synchronized pin has been seen high at two consecutive machine-cycle ticks. If the level drops before that, the qualification starts again. In the outbound direction a watchdog expiry makes the block drive the pin high for a fixed run of 98 oscillator clocks. The core can then reset external parts that share the same line.

A software-writable control bit, `drive_dis`, turns the outbound role off. It is low after reset, so outbound drive is enabled by default. While the block drives the pin it treats the line as high for qualification, whatever the pad reads back. As a result the watchdog pulse resets the core through the same path as an external reset. A watchdog expiry that arrives while a pulse is running starts the 98-clock run again. The watchdog counter, the tick divider and the pad are outside this block.

Top module: `rpin_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `core_rst`, `pin_oe` and `pin_out` are all 0.
- R2: `pin_in` passes through a SYNC_STAGES-deep synchronizer (default 2). `core_rst` goes to 1 on the clock edge at which `mc_tick` is high for the second consecutive time with the synchronized level high. A tick sampled with the level high counts as one machine cycle.
- R3: If the synchronized level is low on any clock edge, the tick count returns to zero. After that, two fresh ticks with the level high are needed before `core_rst` rises.
- R4: With no drive active, `core_rst` returns to 0 one clock edge after the synchronized level goes low, which is SYNC_STAGES+1 edges after `pin_in` falls.
- R5: When `wdt_expire` is high on an edge and `drive_dis` is 0, `pin_oe` and `pin_out` are both 1 for exactly DRIVE_LEN (default 98) consecutive clocks, starting right after that edge. `pin_out` is 1 exactly when `pin_oe` is 1.
- R6: When `drive_dis` is 1, a `wdt_expire` pulse has no effect: `pin_oe` stays 0.
- R7: Setting `drive_dis` to 1 during a drive ends it: `pin_oe` is 0 after the next clock edge.
- R8: A `wdt_expire` pulse during an active drive restarts the count, so `pin_oe` then stays high for DRIVE_LEN clocks counted from that pulse's edge.
- R9: While `pin_oe` is 1, qualification treats the line as high and ignores `pin_in`. Two ticks during a drive raise `core_rst` even when `pin_in` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| pin_in | input | 1 | Raw level read back from the reset pad |
| wdt_expire | input | 1 | One-clock watchdog timeout pulse |
| drive_dis | input | 1 | Control bit; 1 disables the outbound reset pulse |
| core_rst | output | 1 | Qualified reset to the core |
| pin_oe | output | 1 | Pad output enable |
| pin_out | output | 1 | Pad output value |

## Verification
A wrong tick count shows as `core_rst` rising one machine cycle early or late. It can also fail to rise at all after an interrupted high level. Either way it is visible at the edge of the second tick. A wrong drive counter shows as a pulse width other than 98 at `pin_oe`, or as a missed restart. This is seen when the pulse ends, at most about a hundred clocks after the expiry. A broken disable or override path shows within one or two clocks: `pin_oe` rises while disabled, or `core_rst` stays low during a drive with the pad low.

// File: rtl/rpin_pkg.sv
package rpin_pkg;

   localparam int unsigned SYNC_STAGES_DEF = 2;
   localparam int unsigned QUAL_MC_DEF     = 2;
   localparam int unsigned DRIVE_LEN_DEF   = 98;

   // bits needed to hold values 0..maxval
   function automatic int unsigned cnt_bits(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/rpin_in_sync.sv
module rpin_in_sync #(
   parameter int unsigned STAGES = rpin_pkg::SYNC_STAGES_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   initial begin
      if (STAGES > 8) $error("rpin_in_sync: STAGES must not exceed 8");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic chain_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain_q[i] <= 1'b0;
            end else begin
               chain_q[0] <= d;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end

         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rpin_qualify.sv
module rpin_qualify #(
   parameter int unsigned QUAL_MC = rpin_pkg::QUAL_MC_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic mc_tick,
   output logic qual_rst
);

   localparam int unsigned CW = rpin_pkg::cnt_bits(QUAL_MC);
   localparam logic [CW-1:0] LAST_V = CW'(QUAL_MC - 1);

   initial begin
      if (QUAL_MC < 1) $error("rpin_qualify: QUAL_MC must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rst_q <= 1'b0;
      end else if (!lvl) begin
         cnt_q <= '0;
         rst_q <= 1'b0;
      end else if (mc_tick && !rst_q) begin
         if (cnt_q == LAST_V) begin
            rst_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign qual_rst = rst_q;

   assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_q) |-> ($past(mc_tick) && $past(lvl)));

   assert_low_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl |=> (cnt_q == '0 && !rst_q));

endmodule

// File: rtl/rpin_drive.sv
module rpin_drive #(
   parameter int unsigned DRIVE_LEN = rpin_pkg::DRIVE_LEN_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wdt_expire,
   input  logic drive_dis,
   output logic drive_on
);

   localparam int unsigned CW = rpin_pkg::cnt_bits(DRIVE_LEN);
   localparam logic [CW-1:0] LEN_V = CW'(DRIVE_LEN);

   initial begin
      if (DRIVE_LEN < 1) $error("rpin_drive: DRIVE_LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (drive_dis) begin
         cnt_q <= '0;
      end else if (wdt_expire) begin
         cnt_q <= LEN_V;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign drive_on = (cnt_q != '0);

   assert_load_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_expire && !drive_dis) |=> (cnt_q == LEN_V));

   assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q > 1 && !wdt_expire && !drive_dis) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drive_dis |=> !drive_on);

endmodule

// File: rtl/rpin_ctrl.sv
module rpin_ctrl #(
   parameter int unsigned SYNC_STAGES = rpin_pkg::SYNC_STAGES_DEF,
   parameter int unsigned QUAL_MC     = rpin_pkg::QUAL_MC_DEF,
   parameter int unsigned DRIVE_LEN   = rpin_pkg::DRIVE_LEN_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mc_tick,
   input  logic pin_in,
   input  logic wdt_expire,
   input  logic drive_dis,
   output logic core_rst,
   output logic pin_oe,
   output logic pin_out
);

   logic pin_sync;
   logic drive_on;
   logic lvl_eff;

   rpin_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   rpin_drive #(.DRIVE_LEN(DRIVE_LEN)) u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdt_expire (wdt_expire),
      .drive_dis  (drive_dis),
      .drive_on   (drive_on)
   );

   // own drive overrides the pad read-back
   assign lvl_eff = drive_on | pin_sync;

   rpin_qualify #(.QUAL_MC(QUAL_MC)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_eff),
      .mc_tick  (mc_tick),
      .qual_rst (core_rst)
   );

   assign pin_oe  = drive_on;
   assign pin_out = drive_on;

   assert_drive_holds_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe && core_rst) |=> (core_rst || !$past(pin_oe)));

endmodule

// File: tb/rpin_ctrl_tb.sv
module rpin_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst_n, mc_tick, pin_in, wdt_expire, drive_dis;
   logic core_rst, pin_oe, pin_out;
   int   checks = 0;
   int   errors = 0;

   localparam int DRIVE_LEN = 98;

   always #2 clk = ~clk;

   rpin_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .pin_in(pin_in),
      .wdt_expire(wdt_expire), .drive_dis(drive_dis),
      .core_rst(core_rst), .pin_oe(pin_oe), .pin_out(pin_out)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      mc_tick = 1'b1;
      step();
      mc_tick = 1'b0;
   endtask

   task automatic measure_drive(output int n);
      n = 0;
      while (pin_oe && n < 300) begin
         n++;
         if (pin_out !== 1'b1) check("R5 pin_out during drive", pin_out, 1);
         step();
      end
   endtask

   task automatic run_tests();
      int n;
      rst_n = 1'b0; mc_tick = 1'b0; pin_in = 1'b0; wdt_expire = 1'b0; drive_dis = 1'b0;
      repeat (3) step();
      check("R1 core_rst in reset", core_rst, 0);
      check("R1 pin_oe in reset", pin_oe, 0);
      rst_n = 1'b1;
      step();
      check("R1 pin_out after reset", pin_out, 0);
      check("R1 core_rst after reset", core_rst, 0);

      // R2 sweep over tick spacing
      for (int g = 1; g <= 12; g++) begin
         pin_in = 1'b0;
         repeat (4) step();
         pin_in = 1'b1;
         repeat (2) step();
         tick();
         check($sformatf("R2 no reset after one tick gap=%0d", g), core_rst, 0);
         repeat (g - 1) step();
         tick();
         check($sformatf("R2 reset after two ticks gap=%0d", g), core_rst, 1);
      end

      // R4 release timing
      pin_in = 1'b0;
      repeat (2) step();
      check("R4 still held two edges after fall", core_rst, 1);
      step();
      check("R4 released third edge", core_rst, 0);

      // R3 interruption clears count
      pin_in = 1'b1;
      repeat (2) step();
      tick();
      pin_in = 1'b0;
      repeat (3) step();
      pin_in = 1'b1;
      repeat (2) step();
      tick();
      check("R3 one fresh tick after interruption", core_rst, 0);
      repeat (11) step();
      tick();
      check("R3 two fresh ticks", core_rst, 1);
      pin_in = 1'b0;
      repeat (4) step();

      // R5 pulse width
      wdt_expire = 1'b1; step(); wdt_expire = 1'b0;
      check("R5 pin_oe after expiry", pin_oe, 1);
      measure_drive(n);
      check("R5 drive length", n, DRIVE_LEN);
      check("R5 pin_out after drive", pin_out, 0);
      check("R9 core_rst stays low without ticks", core_rst, 0);

      // R8 restart
      wdt_expire = 1'b1; step(); wdt_expire = 1'b0;
      repeat (40) step();
      wdt_expire = 1'b1; step(); wdt_expire = 1'b0;
      measure_drive(n);
      check("R8 length after restart", n, DRIVE_LEN);

      // R6 disabled
      drive_dis = 1'b1;
      wdt_expire = 1'b1; step(); wdt_expire = 1'b0;
      n = 0;
      for (int i = 0; i < 5; i++) begin
         n += pin_oe;
         step();
      end
      check("R6 no drive when disabled", n, 0);
      drive_dis = 1'b0;
      step();

      // R7 disable mid-drive
      wdt_expire = 1'b1; step(); wdt_expire = 1'b0;
      repeat (10) step();
      check("R7 driving before disable", pin_oe, 1);
      drive_dis = 1'b1;
      step();
      check("R7 drive stopped", pin_oe, 0);
      drive_dis = 1'b0;
      repeat (3) step();

      // R9 own drive qualifies
      pin_in = 1'b0;
      wdt_expire = 1'b1; step(); wdt_expire = 1'b0;
      tick();
      check("R9 one tick during drive", core_rst, 0);
      repeat (11) step();
      tick();
      check("R9 reset from own drive", core_rst, 1);
      measure_drive(n);
      step();
      check("R9 released after drive ends", core_rst, 0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule